// File: doc/BRIEF.md
# Module Power State Sequencer

One instance of this block sits beside each core or peripheral. It moves the module between three states: fully running, clock-gated (clock and memory banks off), and power-gated (clock, memory and supply off). It always uses one fixed, safe order of steps. Software issues single-cycle on and off commands. A mode bit, sampled when an off command is accepted, chooses between clock-gating and power-gating. The sequencer then works through handshakes with the fabric, which drains pending requests, with the power switch and with the memory-repair engine. It also steps the isolation, clamp, reset, memory-enable and clock-enable controls one at a time.

A second entry path serves resets raised by other sources, such as a watchdog. The requester asks for a reset, and the sequencer drains the module's network traffic and then grants the request. When the requester withdraws, the sequencer releases the drains. A parameter marks modules of the low-speed class. Such a module can only be clock-gated, whatever the mode bit says.

All control pins are plain levels. No data streams through the block, so it has no valid/ready interface. Every handshake is a four-phase level exchange: request up, acknowledge up, request down, acknowledge down.

Top module: `mod_pwr_sequencer`

## Requirements
- R1: After reset, clock enable and memory enable are 1. Drain requests, network isolation, clamp, module reset, power-down request, power isolation, repair request, reset grant, busy and the ignored flag are all 0. `pwr_state_o` reads 0. Its encoding is 0 = running, 1 = clock-gated, 2 = power-gated.
- R2: An off command accepted while running raises the master drain request on the next clock edge and raises busy. The slave drain request rises only after the master acknowledge is seen. Isolation is applied only after the slave acknowledge is seen.
- R3: Network isolation and the clamp rise on the same edge, before reset is applied. Both drain requests fall on that same edge.
- R4: In clock-gating mode, the remaining shutdown steps run one per cycle: reset rises, memory enable falls, clock enable falls, reset falls. The block then idles with `pwr_state_o` = 1.
- R5: In power-gating mode, the steps after the clock falls are: the power-down request rises, the sequencer waits for the power-down acknowledge, power isolation rises, and then reset falls. `pwr_state_o` ends at 2.
- R6: An on command from the clock-gated state runs one step per cycle: reset rises, clock enable rises, memory enable rises, clamp falls, reset falls, network isolation falls. `pwr_state_o` ends at 0.
- R7: An on command from the power-gated state starts by raising reset. The power-down request then falls and the sequencer waits for the acknowledge to fall. The repair request then rises and the sequencer waits for the repair acknowledge. On a single edge, power isolation and the repair request both fall. The R6 steps then continue from clock enable.
- R8: With the low-speed parameter set, an off command always gives clock gating. The power-down request never rises, even when the mode bit asks for power gating.
- R9: A reset request raised while running drains master and then slave traffic, each step waiting for its acknowledge, and then raises the reset grant. When the request falls, the grant and both drain requests fall on one edge and the block is running again. A reset request has priority over an off command in the same cycle.
- R10: While idle in either the running or the gated state with no command, every control output holds its value.
- R11: Busy is 1 throughout any sequence. A command that arrives while busy is ignored. It sets a sticky ignored flag on the next edge and does not alter the sequence in progress. The next accepted command clears the flag.
- R12: An on command while running, or an off command while gated, does nothing. Busy stays 0 and the ignored flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on_i | input | 1 | Single-cycle wake command |
| cmd_off_i | input | 1 | Single-cycle shutdown command |
| cfg_pwr_mode_i | input | 1 | 1 = shut down with power gating, 0 = clock and memory only |
| xrst_req_i | input | 1 | Reset request from another reset source |
| xrst_ack_o | output | 1 | Grant: traffic drained, reset may proceed |
| mst_drain_req_o | output | 1 | Master-side request drain |
| mst_drain_ack_i | input | 1 | Master drain done |
| slv_drain_req_o | output | 1 | Slave-side request drain |
| slv_drain_ack_i | input | 1 | Slave drain done |
| net_iso_en_o | output | 1 | Network isolation enable |
| clamp_en_o | output | 1 | Forces outgoing requests invalid |
| mod_rst_o | output | 1 | Module reset, active high |
| mem_en_o | output | 1 | Memory bank enable |
| clk_en_o | output | 1 | Clock gate enable |
| pwr_down_req_o | output | 1 | Power switch off request (level) |
| pwr_down_ack_i | input | 1 | Power switch state acknowledge |
| pwr_iso_en_o | output | 1 | Power-domain isolation enable |
| repair_req_o | output | 1 | Memory repair request |
| repair_ack_i | input | 1 | Memory repair done |
| busy_o | output | 1 | Sequence in progress |
| cmd_ignored_o | output | 1 | Sticky: a command was dropped while busy |
| pwr_state_o | output | 2 | Settled state: 0 run, 1 clock-gated, 2 power-gated |

## Verification
An accepted command changes its first output on the edge that samples it, so the bench reads that output at the next falling edge. Each later step of a sequence lands exactly one edge after the previous step, or one edge after the awaited acknowledge becomes visible. For that reason the bench does not predict absolute cycle numbers. It sweeps both modes against acknowledge delays of 0 to 3 cycles. At each falling edge it logs every control output transition as a code (bit index times two plus the new value), and it compares the whole logged order with the arithmetically expected list. The ignored flag and the R12 no-op cases are sampled one falling edge after the offending command. The settled state is read once busy has fallen.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [4:0] {
    ST_ON, SD_MREQ, SD_SREQ, SD_ISO, SD_RST, SD_MEM, SD_CLK, SD_PREQ,
    SD_PISO, SD_RREL, ST_OFF, WU_RST, WU_PREQ, WU_REP, WU_PISO, WU_CLK,
    WU_MEM, WU_CLAMP, WU_RREL, WU_ISO, XR_MREQ, XR_SREQ, XR_ACK
  } seq_st_e;

  typedef struct packed {
    logic mst_req;
    logic slv_req;
    logic net_iso;
    logic clamp;
    logic rst;
    logic mem_en;
    logic clk_en;
    logic pwr_req;
    logic pwr_iso;
    logic rep_req;
    logic xrst_ack;
  } ctl_s;

  localparam int PS_W = 2;
  localparam logic [PS_W-1:0] PS_RUN = 2'd0;
  localparam logic [PS_W-1:0] PS_CLK = 2'd1;
  localparam logic [PS_W-1:0] PS_PWR = 2'd2;

endpackage

// File: rtl/pseq_cmd.sv
module pseq_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic xrst_req,
  input  logic in_on,
  input  logic in_off,
  output logic go_on,
  output logic go_off,
  output logic busy,
  output logic ign_q
);

  logic drop;

  assign busy   = !(in_on || in_off);
  assign go_off = cmd_off && in_on && !xrst_req;
  assign go_on  = cmd_on && in_off;
  // a command is lost while busy, or an off command loses to a reset request
  assign drop   = (busy && (cmd_on || cmd_off)) || (cmd_off && in_on && xrst_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ign_q <= 1'b0;
    else if (drop)            ign_q <= 1'b1;
    else if (go_on || go_off) ign_q <= 1'b0;
  end

  p_busy_cmd_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_on || cmd_off)) |=> ign_q);

  p_noop_no_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ign_q && in_on && cmd_on && !cmd_off) |=> (!ign_q && !busy));

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
  import pseq_pkg::*;
#(
  parameter bit LOW_SPEED = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_on,
  input  logic            go_off,
  input  logic            cfg_pwr_mode,
  input  logic            xrst_req,
  input  logic            mst_ack,
  input  logic            slv_ack,
  input  logic            pwr_ack,
  input  logic            rep_ack,
  output seq_st_e         st,
  output seq_st_e         nxt,
  output logic [PS_W-1:0] ps_q
);

  logic pm_q;
  logic cut_q;
  logic pm_sel;

  generate
    if (LOW_SPEED) begin : g_ls
      assign pm_sel = 1'b0;
    end else begin : g_hs
      assign pm_sel = cfg_pwr_mode;
    end
  endgenerate

  always_comb begin
    nxt = st;
    unique case (st)
      ST_ON:    if (xrst_req) nxt = XR_MREQ;
                else if (go_off) nxt = SD_MREQ;
      SD_MREQ:  if (mst_ack) nxt = SD_SREQ;
      SD_SREQ:  if (slv_ack) nxt = SD_ISO;
      SD_ISO:   nxt = SD_RST;
      SD_RST:   nxt = SD_MEM;
      SD_MEM:   nxt = SD_CLK;
      SD_CLK:   nxt = pm_q ? SD_PREQ : SD_RREL;
      SD_PREQ:  if (pwr_ack) nxt = SD_PISO;
      SD_PISO:  nxt = SD_RREL;
      SD_RREL:  nxt = ST_OFF;
      ST_OFF:   if (go_on) nxt = WU_RST;
      WU_RST:   nxt = cut_q ? WU_PREQ : WU_CLK;
      WU_PREQ:  if (!pwr_ack) nxt = WU_REP;
      WU_REP:   if (rep_ack) nxt = WU_PISO;
      WU_PISO:  nxt = WU_CLK;
      WU_CLK:   nxt = WU_MEM;
      WU_MEM:   nxt = WU_CLAMP;
      WU_CLAMP: nxt = WU_RREL;
      WU_RREL:  nxt = WU_ISO;
      WU_ISO:   nxt = ST_ON;
      XR_MREQ:  if (mst_ack) nxt = XR_SREQ;
      XR_SREQ:  if (slv_ack) nxt = XR_ACK;
      XR_ACK:   if (!xrst_req) nxt = ST_ON;
      default:  nxt = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_ON;
      pm_q  <= 1'b0;
      cut_q <= 1'b0;
      ps_q  <= PS_RUN;
    end else begin
      st <= nxt;
      if (st == ST_ON && nxt == SD_MREQ) pm_q <= pm_sel;
      if (st == SD_PREQ && pwr_ack)      cut_q <= 1'b1;
      else if (st == WU_PREQ && !pwr_ack) cut_q <= 1'b0;
      if (st == SD_RREL)     ps_q <= cut_q ? PS_PWR : PS_CLK;
      else if (st == WU_ISO) ps_q <= PS_RUN;
    end
  end

  p_lowspeed_nopwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    LOW_SPEED |-> (st != SD_PREQ));

  p_wake_repair_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WU_PISO) |=> (st == WU_CLK && !cut_q));

  p_xrst_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && xrst_req) |=> (st == XR_MREQ));

endmodule

// File: rtl/pseq_drive.sv
module pseq_drive
  import pseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e st,
  input  seq_st_e nxt,
  output ctl_s    q
);

  ctl_s d;
  ctl_s rst_val;

  always_comb begin
    rst_val        = '0;
    rst_val.clk_en = 1'b1;
    rst_val.mem_en = 1'b1;
  end

  // each state's action is applied on the edge that enters it
  always_comb begin
    d = q;
    if (nxt != st) begin
      unique case (nxt)
        SD_MREQ, XR_MREQ: d.mst_req = 1'b1;
        SD_SREQ, XR_SREQ: d.slv_req = 1'b1;
        SD_ISO: begin
          d.mst_req = 1'b0;
          d.slv_req = 1'b0;
          d.net_iso = 1'b1;
          d.clamp   = 1'b1;
        end
        SD_RST, WU_RST:   d.rst     = 1'b1;
        SD_MEM:           d.mem_en  = 1'b0;
        SD_CLK:           d.clk_en  = 1'b0;
        SD_PREQ:          d.pwr_req = 1'b1;
        SD_PISO:          d.pwr_iso = 1'b1;
        SD_RREL, WU_RREL: d.rst     = 1'b0;
        WU_PREQ:          d.pwr_req = 1'b0;
        WU_REP:           d.rep_req = 1'b1;
        WU_PISO: begin
          d.rep_req = 1'b0;
          d.pwr_iso = 1'b0;
        end
        WU_CLK:           d.clk_en  = 1'b1;
        WU_MEM:           d.mem_en  = 1'b1;
        WU_CLAMP:         d.clamp   = 1'b0;
        WU_ISO:           d.net_iso = 1'b0;
        XR_ACK:           d.xrst_ack = 1'b1;
        ST_ON: if (st == XR_ACK) begin
          d.mst_req  = 1'b0;
          d.slv_req  = 1'b0;
          d.xrst_ack = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= rst_val;
    else        q <= d;
  end

  p_iso_with_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.clamp) |-> (q.net_iso && !q.rst && !q.mst_req));

  p_rst_under_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.rst) |-> q.clamp);

  p_mem_off_in_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q.mem_en) |-> (q.rst && q.clk_en));

  p_pwr_after_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.pwr_req) |-> (!q.clk_en && !q.mem_en));

  p_iso_release_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q.net_iso) |-> (!q.clamp && !q.rst && q.clk_en && q.mem_en));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ON || st == ST_OFF) && nxt == st) |=> $stable(q));

endmodule

// File: rtl/mod_pwr_sequencer.sv
module mod_pwr_sequencer
  import pseq_pkg::*;
#(
  parameter bit LOW_SPEED = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_on_i,
  input  logic            cmd_off_i,
  input  logic            cfg_pwr_mode_i,
  input  logic            xrst_req_i,
  output logic            xrst_ack_o,
  output logic            mst_drain_req_o,
  input  logic            mst_drain_ack_i,
  output logic            slv_drain_req_o,
  input  logic            slv_drain_ack_i,
  output logic            net_iso_en_o,
  output logic            clamp_en_o,
  output logic            mod_rst_o,
  output logic            mem_en_o,
  output logic            clk_en_o,
  output logic            pwr_down_req_o,
  input  logic            pwr_down_ack_i,
  output logic            pwr_iso_en_o,
  output logic            repair_req_o,
  input  logic            repair_ack_i,
  output logic            busy_o,
  output logic            cmd_ignored_o,
  output logic [PS_W-1:0] pwr_state_o
);

  seq_st_e st, nxt;
  logic    go_on, go_off;
  ctl_s    ctl;

  pseq_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_on  (cmd_on_i),
    .cmd_off (cmd_off_i),
    .xrst_req(xrst_req_i),
    .in_on   (st == ST_ON),
    .in_off  (st == ST_OFF),
    .go_on   (go_on),
    .go_off  (go_off),
    .busy    (busy_o),
    .ign_q   (cmd_ignored_o)
  );

  pseq_fsm #(.LOW_SPEED(LOW_SPEED)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_on       (go_on),
    .go_off      (go_off),
    .cfg_pwr_mode(cfg_pwr_mode_i),
    .xrst_req    (xrst_req_i),
    .mst_ack     (mst_drain_ack_i),
    .slv_ack     (slv_drain_ack_i),
    .pwr_ack     (pwr_down_ack_i),
    .rep_ack     (repair_ack_i),
    .st          (st),
    .nxt         (nxt),
    .ps_q        (pwr_state_o)
  );

  pseq_drive u_drv (
    .clk  (clk),
    .rst_n(rst_n),
    .st   (st),
    .nxt  (nxt),
    .q    (ctl)
  );

  assign mst_drain_req_o = ctl.mst_req;
  assign slv_drain_req_o = ctl.slv_req;
  assign net_iso_en_o    = ctl.net_iso;
  assign clamp_en_o      = ctl.clamp;
  assign mod_rst_o       = ctl.rst;
  assign mem_en_o        = ctl.mem_en;
  assign clk_en_o        = ctl.clk_en;
  assign pwr_down_req_o  = ctl.pwr_req;
  assign pwr_iso_en_o    = ctl.pwr_iso;
  assign repair_req_o    = ctl.rep_req;
  assign xrst_ack_o      = ctl.xrst_ack;

  p_slv_after_mst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_drain_req_o) |-> (mst_drain_req_o && $past(mst_drain_ack_i)));

  p_grant_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xrst_ack_o) |-> (mst_drain_req_o && slv_drain_req_o && busy_o));

endmodule

// File: tb/mod_pwr_sequencer_tb_top.sv
module pseq_responder (
  input  logic clk,
  input  logic rst_n,
  input  int   dly,
  input  logic req,
  output logic ack
);
  int cnt;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack = 1'b0;
      cnt = 0;
    end else if (req != ack) begin
      if (cnt >= dly) begin
        ack = req;
        cnt = 0;
      end else cnt = cnt + 1;
    end else cnt = 0;
  end
endmodule

module mod_pwr_sequencer_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int dly = 0;
  int checks = 0;
  int errors = 0;

  logic cmd_on = 0, cmd_off = 0, cfg_pm = 0, xrst_req = 0;
  logic xrst_ack, mreq, mack, sreq, sack, iso, clamp, mrst, mem, cke, preq, pack, piso, rreq, rack;
  logic busy, ign;
  logic [1:0] pst;

  logic ls_on = 0, ls_off = 0;
  logic ls_xack, ls_mreq, ls_mack, ls_sreq, ls_sack, ls_iso, ls_clamp, ls_rst, ls_mem, ls_cke;
  logic ls_preq, ls_pack, ls_piso, ls_rreq, ls_rack, ls_busy, ls_ign;
  logic [1:0] ls_pst;
  logic ls_preq_seen = 0;

  mod_pwr_sequencer #(.LOW_SPEED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
    .cfg_pwr_mode_i(cfg_pm), .xrst_req_i(xrst_req), .xrst_ack_o(xrst_ack),
    .mst_drain_req_o(mreq), .mst_drain_ack_i(mack),
    .slv_drain_req_o(sreq), .slv_drain_ack_i(sack),
    .net_iso_en_o(iso), .clamp_en_o(clamp), .mod_rst_o(mrst), .mem_en_o(mem),
    .clk_en_o(cke), .pwr_down_req_o(preq), .pwr_down_ack_i(pack),
    .pwr_iso_en_o(piso), .repair_req_o(rreq), .repair_ack_i(rack),
    .busy_o(busy), .cmd_ignored_o(ign), .pwr_state_o(pst));

  mod_pwr_sequencer #(.LOW_SPEED(1'b1)) dut_ls_i (
    .clk(clk), .rst_n(rst_n), .cmd_on_i(ls_on), .cmd_off_i(ls_off),
    .cfg_pwr_mode_i(1'b1), .xrst_req_i(1'b0), .xrst_ack_o(ls_xack),
    .mst_drain_req_o(ls_mreq), .mst_drain_ack_i(ls_mack),
    .slv_drain_req_o(ls_sreq), .slv_drain_ack_i(ls_sack),
    .net_iso_en_o(ls_iso), .clamp_en_o(ls_clamp), .mod_rst_o(ls_rst), .mem_en_o(ls_mem),
    .clk_en_o(ls_cke), .pwr_down_req_o(ls_preq), .pwr_down_ack_i(ls_pack),
    .pwr_iso_en_o(ls_piso), .repair_req_o(ls_rreq), .repair_ack_i(ls_rack),
    .busy_o(ls_busy), .cmd_ignored_o(ls_ign), .pwr_state_o(ls_pst));

  pseq_responder r_m (.clk(clk), .rst_n(rst_n), .dly(dly), .req(mreq), .ack(mack));
  pseq_responder r_s (.clk(clk), .rst_n(rst_n), .dly(dly), .req(sreq), .ack(sack));
  pseq_responder r_p (.clk(clk), .rst_n(rst_n), .dly(dly), .req(preq), .ack(pack));
  pseq_responder r_r (.clk(clk), .rst_n(rst_n), .dly(dly), .req(rreq), .ack(rack));
  pseq_responder l_m (.clk(clk), .rst_n(rst_n), .dly(dly), .req(ls_mreq), .ack(ls_mack));
  pseq_responder l_s (.clk(clk), .rst_n(rst_n), .dly(dly), .req(ls_sreq), .ack(ls_sack));
  pseq_responder l_p (.clk(clk), .rst_n(rst_n), .dly(dly), .req(ls_preq), .ack(ls_pack));
  pseq_responder l_r (.clk(clk), .rst_n(rst_n), .dly(dly), .req(ls_rreq), .ack(ls_rack));

  // transition log: code = bit*2 + new value
  logic [9:0] vec, prev;
  int ev [0:63];
  int ev_n = 0;
  assign vec = {rreq, piso, preq, cke, mem, mrst, clamp, iso, sreq, mreq};

  always @(negedge clk) begin
    if (!rst_n) prev = 10'b0001100000;
    else begin
      for (int i = 0; i < 10; i++)
        if (vec[i] != prev[i] && ev_n < 64) begin
          ev[ev_n] = i*2 + int'(vec[i]);
          ev_n = ev_n + 1;
        end
      prev = vec;
      if (ls_preq) ls_preq_seen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n < 400, req, n, 400);
  endtask

  task automatic cmp_log(input string req, input int exp_q[$]);
    chk(ev_n == exp_q.size(), req, ev_n, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ev_n; i++)
      chk(ev[i] == exp_q[i], req, ev[i], exp_q[i]);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e_clk_sd[$] = '{1,3,0,2,5,7,9,10,12,8};
    int e_pwr_sd[$] = '{1,3,0,2,5,7,9,10,12,15,17,8};
    int e_clk_wu[$] = '{9,13,11,6,8,4};
    int e_pwr_wu[$] = '{9,14,19,16,18,13,11,6,8,4};
    int e_xr[$]     = '{1,3,0,2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(cke && mem, "R1", {cke, mem}, 3);
    chk(vec == 10'b0001100000 && !xrst_ack, "R1", vec, 10'b0001100000);
    chk(!busy && !ign && pst == 2'd0, "R1", {busy, ign, pst}, 0);

    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 4; d++) begin
        dly = d;
        cfg_pm = m[0];
        repeat (6) @(negedge clk);
        ev_n = 0;
        @(negedge clk);
        cmd_off = 1'b1;
        @(negedge clk);
        cmd_off = 1'b0;
        chk(mreq && busy && !sreq, "R2", {mreq, busy, sreq}, 6);
        wait_idle("R2");
        if (m == 0) begin
          cmp_log("R4", e_clk_sd);
          chk(pst == 2'd1, "R4", pst, 1);
        end else begin
          cmp_log("R5", e_pwr_sd);
          chk(pst == 2'd2, "R5", pst, 2);
        end
        chk(iso && clamp, "R3", {iso, clamp}, 3);
        ev_n = 0;
        repeat (20) @(negedge clk);
        chk(ev_n == 0 && !busy, "R10", ev_n, 0);
        @(negedge clk);
        cmd_on = 1'b1;
        @(negedge clk);
        cmd_on = 1'b0;
        wait_idle("R6");
        if (m == 0) cmp_log("R6", e_clk_wu);
        else        cmp_log("R7", e_pwr_wu);
        chk(pst == 2'd0 && vec == 10'b0001100000, "R6", vec, 10'b0001100000);
        ev_n = 0;
        repeat (20) @(negedge clk);
        chk(ev_n == 0, "R10", ev_n, 0);
      end

    // R12 no-op commands
    dly = 1;
    cfg_pm = 1'b0;
    pulse(cmd_on);
    chk(!busy && !ign, "R12", {busy, ign}, 0);
    cmd_off = 1'b1; @(negedge clk); cmd_off = 1'b0;
    wait_idle("R12");
    ev_n = 0;
    pulse(cmd_off);
    chk(!busy && !ign && ev_n == 0, "R12", {busy, ign}, 0);

    // R11 ignored command during wake and during shutdown
    @(negedge clk);
    cmd_on = 1'b1;
    @(negedge clk);
    cmd_on = 1'b0;
    cmd_off = 1'b1;
    @(negedge clk);
    cmd_off = 1'b0;
    chk(ign && busy, "R11", {ign, busy}, 3);
    wait_idle("R11");
    chk(pst == 2'd0 && cke, "R11", pst, 0);
    @(negedge clk);
    cmd_off = 1'b1;
    @(negedge clk);
    cmd_off = 1'b0;
    chk(!ign, "R11", ign, 0);
    wait_idle("R11");
    chk(pst == 2'd1, "R11", pst, 1);
    pulse(cmd_on);
    wait_idle("R11");
    repeat (6) @(negedge clk);

    // R9 external reset handshake, with priority over a same-cycle off command
    ev_n = 0;
    @(negedge clk);
    xrst_req = 1'b1;
    cmd_off = 1'b1;
    @(negedge clk);
    cmd_off = 1'b0;
    chk(mreq && busy, "R9", mreq, 1);
    repeat (20) @(negedge clk);
    chk(xrst_ack && mreq && sreq && !iso, "R9", {xrst_ack, mreq, sreq}, 7);
    chk(ign, "R9", ign, 1);
    xrst_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!xrst_ack && !busy && pst == 2'd0, "R9", {xrst_ack, busy}, 0);
    cmp_log("R9", e_xr);

    // R8 low-speed instance ignores the power mode
    pulse(ls_off);
    repeat (40) @(negedge clk);
    chk(ls_pst == 2'd1 && !ls_cke && !ls_mem, "R8", ls_pst, 1);
    chk(!ls_preq_seen && !ls_piso, "R8", ls_preq_seen, 0);
    pulse(ls_on);
    repeat (40) @(negedge clk);
    chk(ls_pst == 2'd0 && ls_cke && !ls_iso && !ls_busy, "R8", ls_pst, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule